// File: doc/BRIEF.md
# Fractional M/N Audio Clock Generator

This block derives an audio system clock from a fast input clock. It runs entirely in the input clock domain. One of two parent sources is picked by a select bit. Each source is presented as a per-cycle strobe. A phase accumulator adds M on every strobe of the chosen parent and subtracts N when the sum reaches N. Each such overflow yields one output enable pulse, so the average output rate is the parent rate times M/N. A toggle clock flips on every output pulse and gives a square wave at half the pulse rate.

An output select can bypass the divider. In bypass, a strobe from an external reference is passed straight to the output, and the accumulator is held at zero. Two 32-bit registers are reached through a simple synchronous read/write port. The main register holds the parent select, the output select, the divider enable, M and N. The auxiliary register holds two enable flags and a 13-bit D field. While the D-enable flag is clear, D is recomputed as N/2, and only when the auxiliary register itself is written. The two flags read back in each other's positions.

Top module: `audio_clkgen`

## Requirements
- R1: After reset both registers read 0, the output select points at the external reference, and `aud_ce` and `aud_clk` are low.
- R2: The main register (address 0) stores the parent select at bit 31, the output select at bit 30, the divider enable at bit 29, M at bits [21:13] and N at bits [12:0]. All other bits read 0.
- R3: A write to the auxiliary register (address 1) stores the N-enable flag from bit 31 and the D-enable flag from bit 30. If the written bit 30 is 0, the D field at bits [12:0] becomes N/2 (rounded down). If it is 1, D takes the written bits [12:0].
- R4: D never changes except on a write to the auxiliary register. In particular, a change of N in the main register leaves it alone.
- R5: A read of the auxiliary register returns the D-enable flag at bit 31 and the N-enable flag at bit 30.
- R6: With output select 1, divider enable 1, M>0 and N>0, the number of `aud_ce` pulses over W strobes of the selected parent is W*M/N when W is a multiple of N.
- R7: Parent select 0 makes `src_a_stb` drive the accumulator, and 1 makes `src_b_stb` drive it. Strobes on the unselected parent have no effect.
- R8: With output select 0, `aud_ce` equals the value `ext_ref_stb` had one cycle earlier.
- R9: With output select 1 and the divider disabled, or with an active M or N of 0, `aud_ce` and `aud_clk` are held low.
- R10: `aud_clk` inverts in each cycle in which `aud_ce` is high, and only then, apart from the forced low of R9.
- R11: A new M or N written while the divider runs takes effect at the next overflow under the old values, and the accumulator restarts from 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a_stb | input | 1 | Strobe of parent source 0 |
| src_b_stb | input | 1 | Strobe of parent source 1 |
| ext_ref_stb | input | 1 | External reference strobe for bypass |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 1 | Register select: 0 main, 1 auxiliary |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| aud_ce | output | 1 | Output clock-enable pulse |
| aud_clk | output | 1 | Toggle clock derived from aud_ce |

## Verification
The hardest situation to reach is a change of M and N landing mid-period while the divider is running. The bench waits for an output pulse and then writes the new N in the very next cycle. It then times the following pulse gaps: one full old-period gap must come before the new spacing appears. The D-field rules are reached by interleaving main-register writes that change N with auxiliary writes that use both D-enable settings, and reading back after each one.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
  localparam int REG_W     = 32;
  localparam int BIT_PSEL  = 31;
  localparam int BIT_OSEL  = 30;
  localparam int BIT_DIVEN = 29;
  localparam int AUX_NEN   = 31;
  localparam int AUX_DEN   = 30;

  typedef enum logic {
    ADDR_MAIN = 1'b0,
    ADDR_AUX  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/acg_regs.sv
module acg_regs
  import audio_clkgen_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 13,
  parameter int DW = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             rvalid,
  output logic             psel,
  output logic             osel,
  output logic             diven,
  output logic [MW-1:0]    m_cfg,
  output logic [NW-1:0]    n_cfg,
  output logic [DW-1:0]    d_fld
);
  localparam int M_LSB = NW;
  localparam int M_MSB = NW + MW - 1;

  logic nen_q, den_q;
  logic [REG_W-1:0] main_view, aux_view;

  always_comb begin
    main_view                = '0;
    main_view[BIT_PSEL]      = psel;
    main_view[BIT_OSEL]      = osel;
    main_view[BIT_DIVEN]     = diven;
    main_view[M_MSB:M_LSB]   = m_cfg;
    main_view[NW-1:0]        = n_cfg;
    aux_view                 = '0;
    aux_view[AUX_NEN]        = den_q;   // flags come back crossed
    aux_view[AUX_DEN]        = nen_q;
    aux_view[DW-1:0]         = d_fld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psel  <= 1'b0;
      osel  <= 1'b0;
      diven <= 1'b0;
      m_cfg <= '0;
      n_cfg <= '0;
      nen_q <= 1'b0;
      den_q <= 1'b0;
      d_fld <= '0;
    end else if (wr) begin
      if (addr == ADDR_MAIN) begin
        psel  <= wdata[BIT_PSEL];
        osel  <= wdata[BIT_OSEL];
        diven <= wdata[BIT_DIVEN];
        m_cfg <= wdata[M_MSB:M_LSB];
        n_cfg <= wdata[NW-1:0];
      end else begin
        nen_q <= wdata[AUX_NEN];
        den_q <= wdata[AUX_DEN];
        if (wdata[AUX_DEN]) d_fld <= wdata[DW-1:0];
        else                d_fld <= DW'(n_cfg >> 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= (addr == ADDR_MAIN) ? main_view : aux_view;
    end
  end
endmodule

// File: rtl/acg_frac_div.sv
module acg_frac_div #(
  parameter int MW = 9,
  parameter int NW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          stb,
  input  logic [MW-1:0] m_cfg,
  input  logic [NW-1:0] n_cfg,
  output logic          pulse,
  output logic          running
);
  localparam int AW = ((NW > MW) ? NW : MW) + 1;

  logic [AW-1:0] acc, sum;
  logic [MW-1:0] m_act;
  logic [NW-1:0] n_act;
  logic          active, pending, wrap;

  assign active  = (m_act != '0) && (n_act != '0);
  assign running = run_en && active;
  assign pending = (m_cfg != m_act) || (n_cfg != n_act);
  assign sum     = acc + AW'(m_act);
  assign wrap    = sum >= AW'(n_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      m_act <= '0;
      n_act <= '0;
      pulse <= 1'b0;
    end else if (!running) begin
      acc   <= '0;
      pulse <= 1'b0;
      m_act <= m_cfg;
      n_act <= n_cfg;
    end else begin
      pulse <= stb && wrap;
      if (stb) begin
        if (wrap) begin
          acc   <= pending ? '0 : (sum - AW'(n_act));
          m_act <= m_cfg;
          n_act <= n_cfg;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/acg_out_stage.sv
module acg_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic osel,
  input  logic running,
  input  logic div_pulse,
  input  logic ext_stb,
  output logic ce,
  output logic tog
);
  logic ce_nxt, halt;

  assign ce_nxt = osel ? (running && div_pulse) : ext_stb;
  assign halt   = osel && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce  <= 1'b0;
      tog <= 1'b0;
    end else begin
      ce  <= ce_nxt;
      tog <= halt ? 1'b0 : (tog ^ ce_nxt);
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int MW = 9,
  parameter int NW = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_a_stb,
  input  logic             src_b_stb,
  input  logic             ext_ref_stb,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_rvalid,
  output logic             aud_ce,
  output logic             aud_clk
);
  localparam int DW = NW;

  logic          psel_w, osel_w, diven_w, run_w, pulse_w, stb_w;
  logic [MW-1:0] m_w;
  logic [NW-1:0] n_w;
  logic [DW-1:0] d_w;

  acg_regs #(.MW(MW), .NW(NW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rvalid(reg_rvalid),
    .psel(psel_w), .osel(osel_w), .diven(diven_w),
    .m_cfg(m_w), .n_cfg(n_w), .d_fld(d_w)
  );

  assign stb_w = psel_w ? src_b_stb : src_a_stb;

  acg_frac_div #(.MW(MW), .NW(NW)) u_div (
    .clk(clk), .rst(rst), .run_en(osel_w && diven_w), .stb(stb_w),
    .m_cfg(m_w), .n_cfg(n_w), .pulse(pulse_w), .running(run_w)
  );

  acg_out_stage u_out (
    .clk(clk), .rst(rst), .osel(osel_w), .running(run_w),
    .div_pulse(pulse_w), .ext_stb(ext_ref_stb), .ce(aud_ce), .tog(aud_clk)
  );
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int DW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          osel,
  input logic          running,
  input logic          ext,
  input logic          ce,
  input logic          tog,
  input logic          wr,
  input logic          addr,
  input logic [DW-1:0] d_fld,
  input logic [31:0]   rdata
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!ce && !tog && rdata == 32'd0));

  // R8
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !osel |=> (ce == $past(ext)));

  // R9
  halt_low_chk: assert property (@(posedge clk) disable iff (rst)
    (osel && !running) |=> (!ce && !tog));

  // R10
  tog_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tog) |-> ce);

  // R4
  d_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr) |=> $stable(d_fld));
endmodule

bind audio_clkgen audio_clkgen_chk #(.DW(NW)) u_chk (
  .clk(clk), .rst(rst), .osel(osel_w), .running(run_w), .ext(ext_ref_stb),
  .ce(aud_ce), .tog(aud_clk), .wr(reg_wr), .addr(reg_addr),
  .d_fld(d_w), .rdata(reg_rdata)
);

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_a = 1'b0, src_b = 1'b0, ext = 1'b0;
  logic wr = 1'b0, rd = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, ce, tog;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  audio_clkgen uut (
    .clk(clk), .rst(rst), .src_a_stb(src_a), .src_b_stb(src_b),
    .ext_ref_stb(ext), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .reg_rvalid(rvalid),
    .aud_ce(ce), .aud_clk(tog)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", int'(rdata), 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata == e, t, int'(rdata), int'(e));
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr_reg(input logic a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mainw(input bit ps, input bit os, input bit en,
                                        input int m, input int n);
    return {ps, os, en, 7'd0, 9'(m), 13'(n)};
  endfunction

  task automatic cfg(input bit ps, input int m, input int n);
    wr_reg(1'b0, mainw(ps, 1'b1, 1'b0, m, n));
    wr_reg(1'b0, mainw(ps, 1'b1, 1'b1, m, n));
    repeat (8) @(negedge clk);
  endtask

  task automatic count(input int w, output int pulses, output int rises);
    logic prev;
    pulses = 0; rises = 0; prev = tog;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (ce) pulses++;
      if (tog && !prev) rises++;
      prev = tog;
    end
  endtask

  task automatic next_pulse(output int t);
    do @(negedge clk); while (!ce);
    t = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, r, t0, t1, t2, t3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ce == 1'b0 && tog == 1'b0, "R1 outputs low", int'({ce, tog}), 0);
    rd_reg(1'b0, 32'h0, "R1 main reads 0");
    rd_reg(1'b1, 32'h0, "R1 aux reads 0");

    // R2 field layout, unused bits read zero
    wr_reg(1'b0, 32'hFFFF_FFFF);
    rd_reg(1'b0, 32'hE03F_FFFF, "R2 all-ones readback");
    wr_reg(1'b0, mainw(1'b0, 1'b0, 1'b0, 3, 10) | 32'h0FC0_0000);
    rd_reg(1'b0, mainw(1'b0, 1'b0, 1'b0, 3, 10), "R2 M/N readback");

    // R3 auto D = N/2 when D-enable clear
    wr_reg(1'b1, 32'h0);
    rd_reg(1'b1, 32'd5, "R3 D=N/2");
    // R4 N change in main does not touch D
    wr_reg(1'b0, mainw(1'b0, 1'b0, 1'b0, 3, 21));
    rd_reg(1'b1, 32'd5, "R4 D held after N change");
    wr_reg(1'b1, 32'd5);
    rd_reg(1'b1, 32'd10, "R3 rewrite refreshes D");
    // R3/R5 D-enable set keeps written D, flag reads at bit 31
    wr_reg(1'b1, 32'h4000_0123);
    rd_reg(1'b1, 32'h8000_0123, "R5 D-enable swapped, R3 D kept");
    wr_reg(1'b1, 32'h8000_0007);
    rd_reg(1'b1, 32'h4000_000A, "R5 N-enable swapped, R3 D recomputed");

    // R8 bypass passthrough
    wr_reg(1'b0, 32'h0);
    for (int i = 0; i < 12; i++) begin
      logic v;
      v = (i % 3) != 1;
      ext = v;
      @(negedge clk);
      chk(ce == v, "R8 bypass follows ext", int'(ce), int'(v));
    end
    ext = 1'b0;

    // R6 rate, several M/N
    src_a = 1'b1;
    cfg(1'b0, 3, 10);
    count(1000, p, r);
    chk(p == 300, "R6 M=3 N=10 pulses", p, 300);
    chk(r == 150, "R10 toggle rises M=3 N=10", r, 150);
    cfg(1'b0, 1, 2);
    count(100, p, r);
    chk(p == 50, "R6 M=1 N=2 pulses", p, 50);
    cfg(1'b0, 7, 2500);
    count(25000, p, r);
    chk(p == 70, "R6 M=7 N=2500 pulses", p, 70);
    chk(r == 35, "R10 toggle rises M=7 N=2500", r, 35);

    // R7 parent select
    cfg(1'b1, 1, 2);
    count(100, p, r);
    chk(p == 0, "R7 idle parent b gives no pulses", p, 0);
    src_b = 1'b1; src_a = 1'b0;
    repeat (4) @(negedge clk);
    count(100, p, r);
    chk(p == 50, "R7 parent b drives divider", p, 50);
    src_b = 1'b0; src_a = 1'b1;
    cfg(1'b0, 1, 2);
    fork
      begin
        for (int i = 0; i < 220; i++) begin src_a = i[0]; @(negedge clk); end
      end
      begin
        repeat (10) @(negedge clk);
        count(200, p, r);
      end
    join
    chk(p == 50, "R6 half-rate parent strobe", p, 50);
    src_a = 1'b1;

    // R9 stop conditions
    cfg(1'b0, 0, 10);
    count(50, p, r);
    chk(p == 0 && tog == 1'b0, "R9 M=0 stopped", p, 0);
    cfg(1'b0, 2, 0);
    count(50, p, r);
    chk(p == 0 && tog == 1'b0, "R9 N=0 stopped", p, 0);
    wr_reg(1'b0, mainw(1'b0, 1'b1, 1'b0, 1, 2));
    count(50, p, r);
    chk(p == 0 && tog == 1'b0, "R9 divider disabled", p, 0);

    // R11 change lands at next overflow
    cfg(1'b0, 1, 4);
    next_pulse(t0);
    wr_reg(1'b0, mainw(1'b0, 1'b1, 1'b1, 1, 2));
    next_pulse(t1);
    next_pulse(t2);
    next_pulse(t3);
    chk(t1 - t0 == 4, "R11 old period finishes", t1 - t0, 4);
    chk(t2 - t1 == 2, "R11 new period", t2 - t1, 2);
    chk(t3 - t2 == 2, "R11 new period steady", t3 - t2, 2);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule